// File: doc/BRIEF.md
# Exception Priority and Nesting Tracker

This block keeps the service state of a small, fixed set of exception sources and chooses which of them the core should enter next. Every source has a request input and a two-bit state: idle, waiting, in service, or in service with a further request waiting. Exception number 0 is the non-maskable source and number 1 is the hard-fault source. Their urgency is fixed. Numbers 2 and above are ordinary sources, and each has a priority field that software can set.

The block compares the most urgent eligible waiting source with the current execution priority. When that source is strictly more urgent, the block raises an entry offer that carries the source's exception number. The offer is a valid/ready pair. `pre_valid` and `pre_num` are recomputed every cycle from registered state, and from the priority and mask inputs. A valid offer may therefore change its number, or drop away, before it is taken. The core accepts the offer by holding `pre_ready` high in a cycle where `pre_valid` is high. The number shown in that cycle is then entered, and the core takes no other copy. Holding `pre_ready` low simply leaves the offer waiting.

The core signals the end of a handler with `exc_return`, which always retires the most recently entered handler. The block keeps a stack of entered handlers and the priority each one had on entry. The execution priority is always that of the top entry, or thread level when the stack is empty.

Top module: `exc_tracker`

## Requirements
- R1: After reset every source reads idle (00), `pre_valid` is low, `nest_depth` is 0, `thread_mode` is 1 and `exec_rank` equals the thread level, 2 + 2^PRIO_W (10 by default).
- R2: State of exception n is `src_state[2n+1:2n]`, with 00 idle, 01 waiting, 10 in service and 11 in service with a request waiting. A request pulse on an idle source makes it read 01 from the next cycle.
- R3: An accepted offer moves the offered source from 01 to 10 in the next cycle. A request that arrives while the source is in service, including in its entry cycle, leaves it at 11.
- R4: A waiting source that is strictly more urgent than the running handler is offered and, once accepted, nests: both sources read in service, `nest_depth` increases by one and `exec_rank` becomes the new source's rank.
- R5: Exception 0 has rank 0. The mask never blocks it, and it is offered whenever it waits and is not in service. Nothing can be entered above it.
- R6: Exception 1 has rank 1 and outranks every ordinary source, whatever the ordinary source's priority setting.
- R7: Ordinary exception n takes its priority p from `prio_cfg[(n-2)*PRIO_W +: PRIO_W]`, and its rank is 2 + p, so a lower value is more urgent. The rank is captured at entry, so a later change to `prio_cfg` does not alter `exec_rank` for a handler that is already running.
- R8: Among eligible waiting sources, the lowest rank is offered, and ties go to the lowest exception number. A source is offered only if its rank is strictly below `exec_rank`.
- R9: `exc_return` retires the top handler: 10 becomes 00 and 11 becomes 01. `nest_depth` drops by one and `exec_rank` returns to the rank of the new top, or to thread level.
- R10: While `mask_all` is high, no ordinary source is offered. Exceptions 0 and 1 are unaffected.
- R11: In a cycle with `exc_return` high, `pre_ready` is ignored and no entry takes place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_req | input | NUM_CFG+2 | Request pulses, bit n for exception n |
| prio_cfg | input | NUM_CFG*PRIO_W | Priority fields of the ordinary sources |
| mask_all | input | 1 | Blocks all ordinary sources |
| pre_valid | output | 1 | Entry offer present |
| pre_ready | input | 1 | Core accepts the offer |
| pre_num | output | clog2(NUM_CFG+2) | Exception number offered |
| exc_return | input | 1 | Core leaves the top handler |
| src_state | output | 2*(NUM_CFG+2) | Per-source state, two bits each |
| exec_rank | output | clog2(3+2^PRIO_W) | Current execution priority rank |
| nest_depth | output | clog2(NUM_CFG+3) | Number of handlers in service |
| thread_mode | output | 1 | High when no handler is in service |

## Verification
The bench targets equal-rank collisions and the case of a source whose rank equals the running one. A tracker that used "less or equal", or that scanned from the top index down, would offer the wrong number or re-enter at the same level. It fires requests into sources that are already in service and into their entry cycle; a design that let the entry clear win would silently lose the second request. It returns while a retried source is waiting, changes priorities under a running handler, and asserts return and ready together. The second catches a design that re-reads the live priority instead of the captured one, and the third catches a design that enters and pops in the same edge.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_RUN  = 2'b10,
    ST_BOTH = 2'b11
  } exc_state_e;

  function automatic exc_state_e pack_state(input logic act, input logic pend);
    return exc_state_e'({act, pend});
  endfunction

endpackage

// File: rtl/exc_src_state.sv
module exc_src_state (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic enter,
  input  logic leave,
  output logic pend,
  output logic act
);
  logic pend_q, act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      pend_q <= req | (pend_q & ~enter);
      act_q  <= enter | (act_q & ~leave);
    end
  end

  assign pend = pend_q;
  assign act  = act_q;

  assert_enter_from_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
    enter |-> (pend_q && !act_q));

  assert_leave_in_service_R9: assert property (@(posedge clk) disable iff (!rst_n)
    leave |-> act_q);

  assert_req_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> pend_q);

endmodule

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
  parameter int N_EXC  = 8,
  parameter int PRIO_W = 3,
  parameter int RANK_W = 4,
  parameter int NUM_W  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_EXC-1:0]              cand,
  input  logic [(N_EXC-2)*PRIO_W-1:0]   prio_cfg,
  input  logic                          mask_all,
  input  logic [RANK_W-1:0]             exec_rank,
  output logic                          win_valid,
  output logic [NUM_W-1:0]              win_num,
  output logic [RANK_W-1:0]             win_rank
);
  logic [RANK_W-1:0] rank_v [N_EXC];
  logic [N_EXC-1:0]  elig;

  for (genvar g = 0; g < N_EXC; g++) begin : g_rank
    if (g < 2) begin : g_fixed
      assign rank_v[g] = RANK_W'(g);
      assign elig[g]   = cand[g];
    end else begin : g_cfg
      assign rank_v[g] = RANK_W'(2) + RANK_W'(prio_cfg[(g-2)*PRIO_W +: PRIO_W]);
      assign elig[g]   = cand[g] & ~mask_all;
    end
  end

  always_comb begin
    win_valid = 1'b0;
    win_num   = '0;
    win_rank  = exec_rank;
    for (int i = 0; i < N_EXC; i++) begin
      if (elig[i] && (rank_v[i] < win_rank)) begin
        win_valid = 1'b1;
        win_num   = NUM_W'(i);
        win_rank  = rank_v[i];
      end
    end
  end

  assert_winner_eligible_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid |-> elig[win_num]);

  assert_mask_fixed_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_all && win_valid) |-> (win_num < NUM_W'(2)));

endmodule

// File: rtl/exc_nest_stack.sv
module exc_nest_stack #(
  parameter int DEPTH       = 8,
  parameter int NUM_W       = 3,
  parameter int RANK_W      = 4,
  parameter int DEPTH_W     = 4,
  parameter int THREAD_RANK = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               push,
  input  logic [NUM_W-1:0]   push_num,
  input  logic [RANK_W-1:0]  push_rank,
  input  logic               pop,
  output logic [NUM_W-1:0]   top_num,
  output logic [RANK_W-1:0]  top_rank,
  output logic [DEPTH_W-1:0] depth
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [NUM_W-1:0]   num_q  [DEPTH];
  logic [RANK_W-1:0]  rank_q [DEPTH];
  logic [DEPTH_W-1:0] cnt_q;
  logic [IDX_W-1:0]   top_idx;
  logic [IDX_W-1:0]   wr_idx;

  assign top_idx = IDX_W'(cnt_q - DEPTH_W'(1));
  assign wr_idx  = IDX_W'(cnt_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (push) begin
      cnt_q <= cnt_q + DEPTH_W'(1);
    end else if (pop) begin
      cnt_q <= cnt_q - DEPTH_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      num_q[wr_idx]  <= push_num;
      rank_q[wr_idx] <= push_rank;
    end
  end

  always_comb begin
    if (cnt_q == '0) begin
      top_num  = '0;
      top_rank = RANK_W'(THREAD_RANK);
    end else begin
      top_num  = num_q[top_idx];
      top_rank = rank_q[top_idx];
    end
  end

  assign depth = cnt_q;

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (cnt_q < DEPTH_W'(DEPTH)));

  assert_no_underflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));

  assert_push_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (push_rank < top_rank));

  assert_not_both_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(push && pop));

endmodule

// File: rtl/exc_tracker.sv
module exc_tracker #(
  parameter int NUM_CFG = 6,
  parameter int PRIO_W  = 3
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [NUM_CFG+1:0]                   exc_req,
  input  logic [NUM_CFG*PRIO_W-1:0]            prio_cfg,
  input  logic                                 mask_all,
  output logic                                 pre_valid,
  input  logic                                 pre_ready,
  output logic [$clog2(NUM_CFG+2)-1:0]         pre_num,
  input  logic                                 exc_return,
  output logic [2*(NUM_CFG+2)-1:0]             src_state,
  output logic [$clog2(3+(1<<PRIO_W))-1:0]     exec_rank,
  output logic [$clog2(NUM_CFG+3)-1:0]         nest_depth,
  output logic                                 thread_mode
);
  import exc_pkg::*;

  localparam int N_EXC       = NUM_CFG + 2;
  localparam int NUM_W       = $clog2(N_EXC);
  localparam int THREAD_RANK = 2 + (1 << PRIO_W);
  localparam int RANK_W      = $clog2(THREAD_RANK + 1);
  localparam int DEPTH_W     = $clog2(N_EXC + 1);

  logic [N_EXC-1:0]   pend_vec, act_vec, enter_vec, leave_vec;
  logic               accept, do_ret;
  logic [NUM_W-1:0]   win_num, top_num;
  logic [RANK_W-1:0]  win_rank, top_rank;
  logic               win_valid;
  logic [DEPTH_W-1:0] depth;

  for (genvar g = 0; g < N_EXC; g++) begin : g_src
    exc_src_state u_src (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (exc_req[g]),
      .enter (enter_vec[g]),
      .leave (leave_vec[g]),
      .pend  (pend_vec[g]),
      .act   (act_vec[g])
    );
    assign src_state[2*g +: 2] = pack_state(act_vec[g], pend_vec[g]);
  end

  exc_arbiter #(
    .N_EXC  (N_EXC),
    .PRIO_W (PRIO_W),
    .RANK_W (RANK_W),
    .NUM_W  (NUM_W)
  ) u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .cand      (pend_vec & ~act_vec),
    .prio_cfg  (prio_cfg),
    .mask_all  (mask_all),
    .exec_rank (top_rank),
    .win_valid (win_valid),
    .win_num   (win_num),
    .win_rank  (win_rank)
  );

  assign do_ret = exc_return & (depth != '0);
  assign accept = win_valid & pre_ready & ~exc_return;

  always_comb begin
    enter_vec = '0;
    leave_vec = '0;
    if (accept) enter_vec[win_num] = 1'b1;
    if (do_ret) leave_vec[top_num] = 1'b1;
  end

  exc_nest_stack #(
    .DEPTH       (N_EXC),
    .NUM_W       (NUM_W),
    .RANK_W      (RANK_W),
    .DEPTH_W     (DEPTH_W),
    .THREAD_RANK (THREAD_RANK)
  ) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (accept),
    .push_num  (win_num),
    .push_rank (win_rank),
    .pop       (do_ret),
    .top_num   (top_num),
    .top_rank  (top_rank),
    .depth     (depth)
  );

  assign pre_valid   = win_valid;
  assign pre_num     = win_num;
  assign exec_rank   = top_rank;
  assign nest_depth  = depth;
  assign thread_mode = (depth == '0);

  assert_nmi_unblocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_vec[0] && !act_vec[0]) |-> (pre_valid && pre_num == '0));

  assert_entry_runs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> act_vec[$past(pre_num)]);

  assert_return_pops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    do_ret |=> (nest_depth == $past(nest_depth) - DEPTH_W'(1)));

  assert_ret_blocks_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
    exc_return |=> (nest_depth <= $past(nest_depth)));

  assert_thread_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (thread_mode && !pre_valid));

endmodule

// File: tb/exc_tracker_test.sv
module exc_tracker_test;
  localparam int NC = 6;
  localparam int PW = 3;
  localparam int NE = NC + 2;
  localparam int THR = 2 + (1 << PW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NE-1:0] exc_req = '0;
  logic [NC*PW-1:0] prio_cfg = '0;
  logic mask_all = 1'b0;
  logic pre_ready = 1'b0;
  logic exc_return = 1'b0;
  logic pre_valid;
  logic [2:0] pre_num;
  logic [2*NE-1:0] src_state;
  logic [3:0] exec_rank;
  logic [3:0] nest_depth;
  logic thread_mode;

  always #10 clk = ~clk;

  exc_tracker #(.NUM_CFG(NC), .PRIO_W(PW)) uut (
    .clk(clk), .rst_n(rst_n), .exc_req(exc_req), .prio_cfg(prio_cfg),
    .mask_all(mask_all), .pre_valid(pre_valid), .pre_ready(pre_ready),
    .pre_num(pre_num), .exc_return(exc_return), .src_state(src_state),
    .exec_rank(exec_rank), .nest_depth(nest_depth), .thread_mode(thread_mode)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cycles = 0;
  bit m_pend [NE];
  bit m_act  [NE];
  int stk_num [$];
  int stk_rank [$];

  function automatic int rank_of(int n);
    if (n < 2) return n;
    return 2 + int'(prio_cfg[(n-2)*PW +: PW]);
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      $display("FAIL watchdog: actual hang expected completion");
      n_bad++;
      summary();
    end
  end

  task automatic vec(input string tag, input logic [NE-1:0] rq, input logic rdy,
                     input logic rt, input logic mk);
    int best, bnum, erank, edep, st;
    bit ev, bad, acc;
    exc_req = rq; pre_ready = rdy; exc_return = rt; mask_all = mk;
    #2;
    erank = (stk_rank.size() == 0) ? THR : stk_rank[$];
    edep = stk_num.size();
    best = erank; bnum = 0; ev = 0;
    for (int i = 0; i < NE; i++) begin
      if (m_pend[i] && !m_act[i] && (i < 2 || !mk) && rank_of(i) < best) begin
        best = rank_of(i); bnum = i; ev = 1;
      end
    end
    bad = 0;
    if (pre_valid !== ev) begin
      $display("FAIL %s valid: actual %0b expected %0b", tag, pre_valid, ev); bad = 1;
    end else if (ev && int'(pre_num) != bnum) begin
      $display("FAIL %s num: actual %0d expected %0d", tag, pre_num, bnum); bad = 1;
    end
    for (int i = 0; i < NE; i++) begin
      st = int'(m_act[i]) * 2 + int'(m_pend[i]);
      if (int'(src_state[2*i +: 2]) != st) begin
        $display("FAIL %s state[%0d]: actual %0d expected %0d", tag, i, src_state[2*i +: 2], st);
        bad = 1;
      end
    end
    if (int'(exec_rank) != erank) begin
      $display("FAIL %s exec_rank: actual %0d expected %0d", tag, exec_rank, erank); bad = 1;
    end
    if (int'(nest_depth) != edep || thread_mode !== (edep == 0)) begin
      $display("FAIL %s depth: actual %0d/%0b expected %0d", tag, nest_depth, thread_mode, edep);
      bad = 1;
    end
    n_vec++;
    if (bad) n_bad++;
    acc = ev && rdy && !rt;
    @(posedge clk);
    if (rt && stk_num.size() > 0) begin
      m_act[stk_num[$]] = 0;
      void'(stk_num.pop_back());
      void'(stk_rank.pop_back());
    end
    if (acc) begin
      m_pend[bnum] = 0; m_act[bnum] = 1;
      stk_num.push_back(bnum); stk_rank.push_back(best);
    end
    for (int i = 0; i < NE; i++) if (rq[i]) m_pend[i] = 1;
    @(negedge clk);
  endtask

  task automatic drain();
    for (int k = 0; k < 40; k++) vec("R9", '0, 1'b1, stk_num.size() > 0, 1'b0);
  endtask

  initial begin
    for (int i = 0; i < NE; i++) begin m_pend[i] = 0; m_act[i] = 0; end
    // exceptions 2..7 priorities 5,2,2,7,0,3
    prio_cfg = {3'd3, 3'd0, 3'd7, 3'd2, 3'd2, 3'd5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) vec("R1", '0, 1'b0, 1'b0, 1'b0);
    vec("R2", 8'h04, 1'b0, 1'b0, 1'b0);
    vec("R2", '0, 1'b0, 1'b0, 1'b0);
    vec("R3", '0, 1'b1, 1'b0, 1'b0);
    vec("R3", 8'h20, 1'b1, 1'b0, 1'b0);
    vec("R8", '0, 1'b1, 1'b0, 1'b0);
    vec("R4", 8'h08, 1'b0, 1'b0, 1'b0);
    vec("R4", '0, 1'b1, 1'b0, 1'b0);
    vec("R3", 8'h08, 1'b0, 1'b0, 1'b0);
    vec("R3", '0, 1'b0, 1'b0, 1'b0);
    vec("R9", '0, 1'b0, 1'b1, 1'b0);
    vec("R11", '0, 1'b1, 1'b1, 1'b0);
    vec("R9", '0, 1'b0, 1'b0, 1'b0);
    drain();
    vec("R8", 8'h18, 1'b0, 1'b0, 1'b0);
    vec("R8", '0, 1'b0, 1'b0, 1'b0);
    vec("R10", '0, 1'b1, 1'b0, 1'b1);
    vec("R6", 8'h02, 1'b0, 1'b0, 1'b1);
    vec("R6", '0, 1'b0, 1'b0, 1'b0);
    vec("R6", '0, 1'b1, 1'b0, 1'b1);
    vec("R5", 8'h41, 1'b0, 1'b0, 1'b1);
    vec("R5", '0, 1'b1, 1'b0, 1'b1);
    vec("R5", 8'h01, 1'b1, 1'b0, 1'b0);
    vec("R5", '0, 1'b1, 1'b0, 1'b0);
    drain();
    vec("R7", 8'h80, 1'b1, 1'b0, 1'b0);
    vec("R7", '0, 1'b1, 1'b0, 1'b0);
    prio_cfg[5*PW +: PW] = 3'd6;
    vec("R7", '0, 1'b0, 1'b0, 1'b0);
    drain();
    for (int k = 0; k < 4000; k++) begin
      if ($urandom % 50 == 0) prio_cfg = NC*PW'($urandom);
      vec("R4", NE'($urandom & $urandom & $urandom), 1'($urandom),
          (stk_num.size() > 0) && ($urandom % 4 == 0), ($urandom % 6 == 0));
    end
    summary();
  end
endmodule